// File: doc/BRIEF.md
# Duty-Cycled Carrier Wake-Up Controller

This block sequences a low-frequency receiver that is powered on a duty cycle to save energy. It switches the receiver on for a programmable number of slow ticks and then off for another programmable number of ticks. While the receiver is on, the block counts carrier edge pulses. The window is validated when enough edges arrive before the window ends. The edge count starts again at zero in every window.

Two modes share this validation path. In carrier-detect mode, the block counts consecutive validated windows. When the programmed number is reached, it raises a wake flag and, if the interrupt is enabled, an interrupt to the host. It then holds with the receiver off until software clears the flag, and resumes with a full off time. In data mode, a validated window keeps the receiver powered, turns on the averaging filter and searches for a sync word. A sync match moves the block into a receive state until the telegram decoder reports that the message is done. If no sync match arrives within a programmable timeout, the block gives up and returns to the duty cycle.

All durations are counted in ticks of a slow clock-enable input. The reset is synchronous and active low.

Top module: `carrier_wake_ctrl`

## Requirements
- R1: Outside a message, `rx_en` is low for `off_ticks` ticks, then high for `on_ticks` ticks, and this repeats. `rx_en` is also high during sync search and during receive, and low otherwise.
- R2: The carrier edge count is cleared on every entry into an on window. Edges seen in an earlier window never count toward validation.
- R3: A window is validated when the edge count, as registered before the current cycle, is at least `edge_need`. An edge that arrives in the same cycle as the tick that ends the window is too late. An unvalidated window that reaches its last tick returns to the off time.
- R4: In data mode (`mode_cd`=0), validation moves the block to sync search in the next cycle. `rx_en` stays high and `filt_en` goes high. Validation takes priority over a window end in the same cycle.
- R5: Sync search lasts at most `timeout_ticks` ticks. When it times out, `rx_en` and `filt_en` drop and the off time begins. A `sync_hit` in the same cycle as the timeout tick wins.
- R6: In carrier-detect mode (`mode_cd`=1), a validated window ends at once and starts the off time. The window that completes `win_need` consecutive validations instead sets `wake_flag`.
- R7: The consecutive-window count returns to zero whenever an on window ends without validation.
- R8: `irq` is high exactly while `wake_flag` and `irq_en` are both high.
- R9: While `wake_flag` is high, `rx_en` stays low and carrier edges are ignored. A `flag_clr` pulse clears the flag and starts a full off time of `off_ticks` ticks.
- R10: `sync_hit` during sync search enters receive, where `rx_busy`, `rx_en` and `filt_en` are high. A `msg_done` pulse returns the block to the off time.
- R11: A value of zero for `on_ticks`, `off_ticks`, `timeout_ticks` or `win_need` acts as one. An `edge_need` of zero validates in the first cycle of a window.
- R12: While `rst_n` is low at a clock edge, all outputs are low and the block is in the off time with all counters cleared.
- R13: `flag_clr` has no effect outside the wake hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | Slow clock enable that paces all durations |
| mode_cd | input | 1 | 1 selects carrier-detect mode, 0 selects data mode |
| irq_en | input | 1 | Interrupt enable for the wake flag |
| on_ticks | input | TW | Length of the on window, in ticks |
| off_ticks | input | TW | Length of the off time, in ticks |
| timeout_ticks | input | TW | Limit for the sync search, in ticks |
| edge_need | input | EW | Carrier edges needed to validate a window |
| win_need | input | CW | Consecutive validated windows needed before wake |
| carrier_edge | input | 1 | One-cycle pulse for each carrier edge |
| sync_hit | input | 1 | One-cycle pulse when the sync word matches |
| msg_done | input | 1 | One-cycle pulse when the telegram has ended |
| flag_clr | input | 1 | Software strobe that clears the wake flag |
| rx_en | output | 1 | Receiver power enable |
| filt_en | output | 1 | Averaging filter enable |
| wake_flag | output | 1 | Carrier-detect wake flag |
| irq | output | 1 | Interrupt request to the host |
| rx_busy | output | 1 | Telegram receive state indication |

## Verification
Two pairs of events can fall in the same cycle. The first is an edge count that reaches `edge_need` on the cycle whose tick also ends the on window. The second is a `sync_hit` that arrives on the tick that ends the sync search. The bench holds `tick` high and places three edges so that the count completes exactly on the last window cycle. It then places them one cycle later, and expects sync search in the first case and the off time in the second. It also places a `sync_hit` on the fifth cycle of a five-tick search and expects `rx_busy`. Random phases with sparse ticks produce many more of these collisions, and each one is judged against a cycle-level reference model.

// File: rtl/cwc_pkg.sv
package cwc_pkg;

    typedef enum logic [2:0] {
        ST_OFF  = 3'd0,
        ST_ON   = 3'd1,
        ST_SYNC = 3'd2,
        ST_RECV = 3'd3,
        ST_HOLD = 3'd4
    } cwc_state_e;

endpackage

// File: rtl/cwc_tick_timer.sv
// Tick counter for the current phase; expire flags the tick that completes the limit.
module cwc_tick_timer #(
    parameter int TW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          clr,
    input  logic [TW-1:0] limit,
    output logic          expire
);
    localparam logic [TW-1:0] CNT_MAX = {TW{1'b1}};

    logic [TW-1:0] cnt_d, cnt_q;
    logic [TW:0]   nxt_w;
    logic [TW:0]   lim_w;

    always_comb begin
        nxt_w  = {1'b0, cnt_q} + {{TW{1'b0}}, 1'b1};
        lim_w  = (limit == '0) ? {{TW{1'b0}}, 1'b1} : {1'b0, limit};
        expire = tick && (nxt_w >= lim_w);
        cnt_d  = cnt_q;
        if (clr) begin
            cnt_d = '0;
        end else if (tick && (cnt_q != CNT_MAX)) begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    // Without a tick or clear the phase time must not move (duty timing, R1).
    assert_timer_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !tick) |=> $stable(cnt_q));

endmodule

// File: rtl/cwc_edge_count.sv
// Saturating count of carrier edges within one on window.
module cwc_edge_count #(
    parameter int EW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          inc,
    output logic [EW-1:0] count
);
    localparam logic [EW-1:0] CNT_MAX = {EW{1'b1}};

    logic [EW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr) begin
            cnt_d = '0;
        end else if (inc && (cnt_q != CNT_MAX)) begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign count = cnt_q;

    // A new window always starts from an empty count.
    assert_window_fresh_R2: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (count == '0));

    // Once at the ceiling the count stays there until cleared.
    assert_no_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q == CNT_MAX && !clr) |=> (cnt_q == CNT_MAX));

endmodule

// File: rtl/carrier_wake_ctrl.sv
module carrier_wake_ctrl #(
    parameter int TW = 8,
    parameter int EW = 6,
    parameter int CW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          mode_cd,
    input  logic          irq_en,
    input  logic [TW-1:0] on_ticks,
    input  logic [TW-1:0] off_ticks,
    input  logic [TW-1:0] timeout_ticks,
    input  logic [EW-1:0] edge_need,
    input  logic [CW-1:0] win_need,
    input  logic          carrier_edge,
    input  logic          sync_hit,
    input  logic          msg_done,
    input  logic          flag_clr,
    output logic          rx_en,
    output logic          filt_en,
    output logic          wake_flag,
    output logic          irq,
    output logic          rx_busy
);
    import cwc_pkg::*;

    localparam logic [TW-1:0] PHASE_IDLE = {TW{1'b1}};

    typedef struct packed {
        cwc_state_e    st;
        logic [CW-1:0] wins;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic          tmr_exp;
    logic          tmr_clr;
    logic [TW-1:0] tmr_lim;
    logic          edge_clr;
    logic          edge_inc;
    logic [EW-1:0] edge_cnt;
    logic          validated;
    logic [CW:0]   wins_nxt;
    logic [CW:0]   wins_lim;

    // Limit of the phase that is running now.
    always_comb begin
        unique case (ctl_q.st)
            ST_OFF:  tmr_lim = off_ticks;
            ST_ON:   tmr_lim = on_ticks;
            ST_SYNC: tmr_lim = timeout_ticks;
            default: tmr_lim = PHASE_IDLE;
        endcase
    end

    cwc_tick_timer #(.TW(TW)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick   (tick),
        .clr    (tmr_clr),
        .limit  (tmr_lim),
        .expire (tmr_exp)
    );

    cwc_edge_count #(.EW(EW)) u_edges (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (edge_clr),
        .inc   (edge_inc),
        .count (edge_cnt)
    );

    // Next-state computation for the whole controller.
    always_comb begin
        ctl_d     = ctl_q;
        validated = (edge_cnt >= edge_need);
        wins_nxt  = {1'b0, ctl_q.wins} + {{CW{1'b0}}, 1'b1};
        wins_lim  = (win_need == '0) ? {{CW{1'b0}}, 1'b1} : {1'b0, win_need};

        unique case (ctl_q.st)
            ST_OFF: begin
                if (tmr_exp) ctl_d.st = ST_ON;
            end
            ST_ON: begin
                if (validated) begin
                    if (!mode_cd) begin
                        ctl_d.st   = ST_SYNC;
                        ctl_d.wins = '0;
                    end else if (wins_nxt >= wins_lim) begin
                        ctl_d.st   = ST_HOLD;
                        ctl_d.wins = '0;
                    end else begin
                        ctl_d.st   = ST_OFF;
                        ctl_d.wins = wins_nxt[CW-1:0];
                    end
                end else if (tmr_exp) begin
                    ctl_d.st   = ST_OFF;
                    ctl_d.wins = '0;
                end
            end
            ST_SYNC: begin
                if (sync_hit) begin
                    ctl_d.st = ST_RECV;
                end else if (tmr_exp) begin
                    ctl_d.st   = ST_OFF;
                    ctl_d.wins = '0;
                end
            end
            ST_RECV: begin
                if (msg_done) begin
                    ctl_d.st   = ST_OFF;
                    ctl_d.wins = '0;
                end
            end
            ST_HOLD: begin
                if (flag_clr) begin
                    ctl_d.st   = ST_OFF;
                    ctl_d.wins = '0;
                end
            end
            default: begin
                ctl_d.st   = ST_OFF;
                ctl_d.wins = '0;
            end
        endcase

        tmr_clr  = (ctl_d.st != ctl_q.st);
        edge_clr = (ctl_d.st == ST_ON) && (ctl_q.st != ST_ON);
        edge_inc = carrier_edge && (ctl_q.st == ST_ON);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q.st   <= ST_OFF;
            ctl_q.wins <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign rx_en     = (ctl_q.st == ST_ON) || (ctl_q.st == ST_SYNC) || (ctl_q.st == ST_RECV);
    assign filt_en   = (ctl_q.st == ST_SYNC) || (ctl_q.st == ST_RECV);
    assign rx_busy   = (ctl_q.st == ST_RECV);
    assign wake_flag = (ctl_q.st == ST_HOLD);
    assign irq       = wake_flag && irq_en;

    // The filter only ever starts from a window that was already powered.
    assert_filter_from_on_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(filt_en) |-> ($past(rx_en) && rx_en));

    // The wake flag stays until software clears it.
    assert_flag_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (wake_flag && !flag_clr) |=> (wake_flag && !rx_en));

    // Clearing the flag leads into an off time.
    assert_clear_to_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (wake_flag && flag_clr) |=> (!wake_flag && !rx_en));

    // A sync match during the search always opens the receive state.
    assert_sync_enters_rx_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (filt_en && !rx_busy && sync_hit) |=> rx_busy);

    // Message end powers the receiver down.
    assert_done_powers_down_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_busy && msg_done) |=> !rx_en);

    // An unvalidated window end forgets all earlier validations.
    assert_streak_reset_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.st == ST_ON && !validated && tmr_exp) |=> (ctl_q.wins == '0));

endmodule

// File: tb/carrier_wake_ctrl_test.sv
`timescale 1ns/1ps
module carrier_wake_ctrl_test;
    localparam int TW = 8;
    localparam int EW = 6;
    localparam int CW = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick = 1'b0, mode_cd = 1'b0, irq_en = 1'b0;
    logic [TW-1:0] on_ticks = '0, off_ticks = '0, timeout_ticks = '0;
    logic [EW-1:0] edge_need = '0;
    logic [CW-1:0] win_need = '0;
    logic carrier_edge = 1'b0, sync_hit = 1'b0, msg_done = 1'b0, flag_clr = 1'b0;
    logic rx_en, filt_en, wake_flag, irq, rx_busy;

    int n_cmp = 0;
    int n_mis = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    carrier_wake_ctrl #(.TW(TW), .EW(EW), .CW(CW)) uut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .mode_cd(mode_cd), .irq_en(irq_en),
        .on_ticks(on_ticks), .off_ticks(off_ticks), .timeout_ticks(timeout_ticks),
        .edge_need(edge_need), .win_need(win_need), .carrier_edge(carrier_edge),
        .sync_hit(sync_hit), .msg_done(msg_done), .flag_clr(flag_clr),
        .rx_en(rx_en), .filt_en(filt_en), .wake_flag(wake_flag), .irq(irq), .rx_busy(rx_busy)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_mis++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_mis);
    endtask

    function automatic int lim1(input int v);
        return (v == 0) ? 1 : v;
    endfunction

    // Reference model: 0 off, 1 on, 2 sync search, 3 receive, 4 hold.
    int m_st = 0, m_tmr = 0, m_edges = 0, m_wins = 0;

    always @(posedge clk) begin
        int nst, nwins, nedges;
        if (!rst_n) begin
            m_st = 0; m_tmr = 0; m_edges = 0; m_wins = 0;
        end else begin
            nst = m_st; nwins = m_wins; nedges = m_edges;
            case (m_st)
                0: if (tick && m_tmr + 1 >= lim1(int'(off_ticks))) nst = 1;
                1: begin
                    if (m_edges >= int'(edge_need)) begin
                        if (!mode_cd) begin nst = 2; nwins = 0; end
                        else if (m_wins + 1 >= lim1(int'(win_need))) begin nst = 4; nwins = 0; end
                        else begin nst = 0; nwins = m_wins + 1; end
                    end else if (tick && m_tmr + 1 >= lim1(int'(on_ticks))) begin
                        nst = 0; nwins = 0;
                    end
                end
                2: begin
                    if (sync_hit) nst = 3;
                    else if (tick && m_tmr + 1 >= lim1(int'(timeout_ticks))) begin nst = 0; nwins = 0; end
                end
                3: if (msg_done) begin nst = 0; nwins = 0; end
                default: if (flag_clr) begin nst = 0; nwins = 0; end
            endcase
            if (m_st == 1 && carrier_edge) nedges = m_edges + 1;
            if (nst == 1 && m_st != 1) nedges = 0;
            if (nst != m_st) m_tmr = 0;
            else if (tick) m_tmr = m_tmr + 1;
            m_st = nst; m_wins = nwins; m_edges = nedges;
        end
    end

    // Cycle-level comparison against the model.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk("R1 rx_en vs model", int'(rx_en), int'(m_st == 1 || m_st == 2 || m_st == 3));
            chk("R4 filt_en vs model", int'(filt_en), int'(m_st == 2 || m_st == 3));
            chk("R10 rx_busy vs model", int'(rx_busy), int'(m_st == 3));
            chk("R6 wake_flag vs model", int'(wake_flag), int'(m_st == 4));
            chk("R8 irq vs model", int'(irq), int'(m_st == 4 && irq_en));
        end
    end

    task automatic cyc();
        @(negedge clk);
        #1;
    endtask

    task automatic wait_rx_rise();
        while (!rx_en) cyc();
    endtask

    task automatic give_edges(input int n);
        carrier_edge = 1'b1;
        repeat (n) cyc();
        carrier_edge = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_cmp++; n_mis++;
        $display("FAIL watchdog expired actual=1 expected=0");
        done = 1'b1;
        summary();
        $finish;
    end

    initial begin
        int n;
        void'($urandom(32'h00c0ffee));
        tick = 1'b1; on_ticks = 4; off_ticks = 3; timeout_ticks = 5;
        edge_need = 3; win_need = 2; mode_cd = 1'b0; irq_en = 1'b1;
        repeat (4) cyc();
        // R12: outputs idle under reset
        chk("R12 reset outputs", int'({rx_en, filt_en, wake_flag, irq, rx_busy}), 0);
        rst_n = 1'b1;

        // R1: off time then on time
        n = 0;
        do begin cyc(); n++; end while (!rx_en);
        chk("R1 first off length", n, 3);
        n = 0;
        while (rx_en) begin n++; cyc(); end
        chk("R3 unvalidated on length", n, 4);
        n = 0;
        while (!rx_en) begin n++; cyc(); end
        chk("R1 off length", n, 3);

        // R4: count completes on the last window cycle; validation wins
        give_edges(3);
        cyc();
        chk("R4 filt after validation", int'(filt_en), 1);
        chk("R4 rx stays on", int'(rx_en), 1);
        n = 0;
        while (filt_en) begin n++; cyc(); end
        chk("R5 sync search length", n, 5);
        chk("R5 rx off after timeout", int'(rx_en), 0);

        // R3: edge on the expiring tick is too late
        wait_rx_rise();
        cyc();
        give_edges(3);
        cyc();
        chk("R3 late edge leaves off", int'(rx_en), 0);
        chk("R3 late edge no filter", int'(filt_en), 0);

        // R10: sync hit then message done
        wait_rx_rise();
        give_edges(3);
        cyc();
        sync_hit = 1'b1; cyc(); sync_hit = 1'b0;
        chk("R10 receive entered", int'(rx_busy), 1);
        repeat (10) cyc();
        chk("R10 receive held", int'(rx_busy), 1);
        msg_done = 1'b1; cyc(); msg_done = 1'b0;
        chk("R10 done powers down", int'(rx_en), 0);

        // R5: sync hit on the timeout tick wins
        wait_rx_rise();
        give_edges(3);
        cyc();
        repeat (4) cyc();
        sync_hit = 1'b1; cyc(); sync_hit = 1'b0;
        chk("R5 sync beats timeout", int'(rx_busy), 1);
        msg_done = 1'b1; cyc(); msg_done = 1'b0;

        // R6: carrier-detect needs two consecutive windows
        mode_cd = 1'b1; on_ticks = 6;
        wait_rx_rise();
        give_edges(3);
        cyc();
        chk("R6 first valid window ends", int'(rx_en), 0);
        chk("R6 no flag yet", int'(wake_flag), 0);
        wait_rx_rise();
        give_edges(3);
        cyc();
        chk("R6 flag after second window", int'(wake_flag), 1);
        chk("R8 irq with enable", int'(irq), 1);
        irq_en = 1'b0; cyc();
        chk("R8 irq masked", int'(irq), 0);
        irq_en = 1'b1;

        // R9: hold ignores carrier, clear restarts with a full off time
        carrier_edge = 1'b1;
        repeat (20) cyc();
        carrier_edge = 1'b0;
        chk("R9 flag held", int'(wake_flag), 1);
        chk("R9 receiver off in hold", int'(rx_en), 0);
        flag_clr = 1'b1; cyc(); flag_clr = 1'b0;
        chk("R9 flag cleared", int'(wake_flag), 0);
        n = 0;
        while (!rx_en) begin n++; cyc(); end
        chk("R9 off time after clear", n, 3);

        // R7: a failed window breaks the streak
        give_edges(3);
        cyc();
        wait_rx_rise();
        while (rx_en) cyc();
        wait_rx_rise();
        give_edges(3);
        cyc();
        chk("R7 streak restarted", int'(wake_flag), 0);
        wait_rx_rise();
        give_edges(3);
        cyc();
        chk("R7 flag after new streak", int'(wake_flag), 1);
        flag_clr = 1'b1; cyc(); flag_clr = 1'b0;

        // R13: clear strobe outside hold does nothing
        wait_rx_rise();
        flag_clr = 1'b1; cyc(); flag_clr = 1'b0;
        chk("R13 clear ignored in window", int'(rx_en), 1);

        // R11: zero limits act as one tick
        on_ticks = 0; off_ticks = 0;
        while (rx_en) cyc();
        n = 0;
        while (!rx_en) begin n++; cyc(); end
        chk("R11 zero off length", n, 1);
        n = 0;
        while (rx_en) begin n++; cyc(); end
        chk("R11 zero on length", n, 1);

        // Random phases, judged by the model
        for (int blk = 0; blk < 10; blk++) begin
            int epct;
            epct = 20 + int'($urandom % 70);
            mode_cd = $urandom % 2;
            on_ticks = $urandom % 8;
            off_ticks = $urandom % 8;
            timeout_ticks = $urandom % 10;
            edge_need = $urandom % 7;
            win_need = $urandom % 4;
            for (int c = 0; c < 2500; c++) begin
                cyc();
                tick = ($urandom % 3) == 0;
                carrier_edge = int'($urandom % 100) < epct;
                sync_hit = ($urandom % 20) == 0;
                msg_done = ($urandom % 15) == 0;
                flag_clr = ($urandom % 25) == 0;
                irq_en = ($urandom % 8) != 0;
            end
        end
        cyc();
        done = 1'b1;
        summary();
        $finish;
    end
endmodule